// File: doc/BRIEF.md
# Request Pacer and Work-Unit Deadline Monitor

This block sits next to a memory-to-memory DMA channel and does two independent jobs. The first is pacing. The channel's raw transfer request passes to the interconnect only after a programmed number of clock cycles has elapsed since the previous granted request. Two limit values are special: a limit of zero lets requests through on every cycle, and an all-ones limit blocks every request for as long as it is programmed.

The second job is a deadline watch on each work unit. A budget counter is reloaded from the monitor register whenever:
- either register is written,
- a work unit completes, or
- an autobuffer wraps.

The counter counts down on every cycle in which a work unit is active. If it reaches zero before the unit completes, a sticky error flag rises and the error code reads 0x6. The counter then rests at zero until the next reload. The expiry is only reported: requests keep flowing and the unit keeps running. A monitor value of zero turns the deadline check off. Software clears the flag by pulsing a clear strobe.

Top module: `pace_guard`

## Requirements
- R1: After reset, the limit and monitor registers are zero, `mon_cur` is 0, `err_flag` is 0, `err_code` is 0x0, and `req_out` is 0 while `raw_req` is 0.
- R2: With limit 0, `req_out` equals `raw_req` in every cycle, including cycles directly after a grant.
- R3: With limit L in 1..0xFFFE, two granted requests (`req_out` and `grant` both high at a clock edge) are at least L cycles apart. Under a permanent request and grant, `req_out` is high exactly every L-th cycle.
- R4: With limit 0xFFFF, `req_out` stays 0 whatever `raw_req` and `grant` do. After the limit is rewritten to 0, requests pass again at once.
- R5: `req_out` is never 1 while `raw_req` is 0.
- R6: A register write (`cfg_wr`), a `wu_done` pulse or a `wrap_pulse` loads `mon_cur` with the monitor register value, and a write uses its new value. A register write has `cfg_sel`=0 for the limit register (low 16 bits of `cfg_wdata`) and `cfg_sel`=1 for the monitor register (all 32 bits).
- R7: While `wu_active` is 1, no reload occurs, the monitor register is non-zero and `mon_cur` is non-zero, `mon_cur` decreases by one per cycle.
- R8: While `wu_active` is 0 and no reload occurs, `mon_cur` holds its value.
- R9: When `mon_cur` steps from 1 to 0 during an active unit, `err_flag` reads 1 and `err_code` reads 0x6 from the next cycle on, and `mon_cur` stays 0 until a reload. If `wu_done` arrives in the cycle where `mon_cur` is 1, the error is not raised.
- R10: With the monitor register at 0, no active period raises the error and `mon_cur` stays 0.
- R11: An expiry does not gate requests: `req_out` keeps following the pacing rules while `err_flag` is 1.
- R12: `err_flag` stays 1 until an `err_clr` pulse. A clear returns `err_flag` to 0 and `err_code` to 0x0. A new expiry in the same cycle as a clear takes priority.
- R13: A request that is passed but not granted stays passed; the spacing count restarts only on a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_req | input | 1 | Transfer request from the DMA channel |
| grant | input | 1 | Interconnect grant for the passed request |
| wu_active | input | 1 | A work unit is in progress |
| wu_done | input | 1 | One-cycle pulse: work unit completed |
| wrap_pulse | input | 1 | One-cycle pulse: autobuffer wrapped |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 limit, 1 monitor |
| cfg_wdata | input | 32 | Register write data |
| err_clr | input | 1 | Write-one-to-clear strobe for the error flag |
| req_out | output | 1 | Paced request toward the interconnect |
| mon_cur | output | 32 | Live value of the deadline counter |
| err_flag | output | 1 | Sticky deadline-expired flag |
| err_code | output | 4 | Error code: 0x6 when expired, 0x0 otherwise |

## Verification
The bench builds the block with its default widths: a 16-bit limit and a 32-bit monitor. The full-width limit makes the all-ones stop value 0xFFFF directly programmable next to ordinary small spacings of 3 and 4. Monitor budgets of 2 to 10 cycles put expiry, on-time completion in the last budget cycle, and a clear colliding with a fresh expiry within a few dozen cycles of each other.

// File: rtl/pace_pkg.sv
package pace_pkg;

    // Register select encoding on cfg_sel
    typedef enum logic {
        REG_LIMIT   = 1'b0,
        REG_MONITOR = 1'b1
    } reg_sel_e;

    localparam int ERR_CODE_W = 4;
    localparam logic [ERR_CODE_W-1:0] ERR_NONE     = 4'h0;
    localparam logic [ERR_CODE_W-1:0] ERR_DEADLINE = 4'h6;

    // Per-cycle events of the deadline counter
    typedef struct packed {
        logic reload;
        logic tick;
        logic expire;
    } mon_evt_t;

    function automatic logic [ERR_CODE_W-1:0] code_of(input logic flag);
        return flag ? ERR_DEADLINE : ERR_NONE;
    endfunction

endpackage

// File: rtl/pace_regs.sv
module pace_regs import pace_pkg::*; #(
    parameter int LIM_W = 16,
    parameter int MON_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [MON_W-1:0] cfg_wdata,
    output logic [LIM_W-1:0] lim_q,
    output logic [MON_W-1:0] mon_q,
    output logic [MON_W-1:0] mon_nxt
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(cfg_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_q <= '0;
            mon_q <= '0;
        end else if (cfg_wr) begin
            if (sel == REG_LIMIT) lim_q <= cfg_wdata[LIM_W-1:0];
            else                  mon_q <= cfg_wdata;
        end
    end

    // Value the monitor register holds after this edge
    always_comb begin
        mon_nxt = mon_q;
        if (cfg_wr && sel == REG_MONITOR) mon_nxt = cfg_wdata;
    end
endmodule

// File: rtl/pace_spacer.sv
module pace_spacer #(
    parameter int LIM_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_req,
    input  logic             grant,
    input  logic [LIM_W-1:0] limit,
    output logic             req_out
);
    localparam logic [LIM_W-1:0] STOP_ALL = '1;
    localparam logic [LIM_W-1:0] ONE      = LIM_W'(1);

    logic [LIM_W-1:0] gap_q;
    logic             blocked, open_win, take;

    assign blocked  = (limit == STOP_ALL);
    assign open_win = (limit == '0) || (gap_q == '0);
    assign req_out  = raw_req && !blocked && open_win;
    assign take     = req_out && grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
        end else if (take) begin
            gap_q <= (limit == '0) ? '0 : limit - ONE;
        end else if (gap_q != '0) begin
            gap_q <= gap_q - ONE;
        end
    end
endmodule

// File: rtl/pace_deadline.sv
module pace_deadline import pace_pkg::*; #(
    parameter int MON_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic [MON_W-1:0] reload_val,
    input  logic             active,
    input  logic             enable,
    output logic [MON_W-1:0] cur,
    output logic             expire
);
    localparam logic [MON_W-1:0] ONE = MON_W'(1);

    mon_evt_t evt;

    always_comb begin
        evt.reload = reload;
        evt.tick   = active && enable && (cur != '0) && !reload;
        evt.expire = evt.tick && (cur == ONE);
    end

    assign expire = evt.expire;

    always_ff @(posedge clk) begin
        if (rst)              cur <= '0;
        else if (evt.reload)  cur <= reload_val;
        else if (evt.tick)    cur <= cur - ONE;
    end
endmodule

// File: rtl/pace_errlat.sv
module pace_errlat import pace_pkg::*; (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  expire,
    input  logic                  clr,
    output logic                  flag,
    output logic [ERR_CODE_W-1:0] code
);
    always_ff @(posedge clk) begin
        if (rst)         flag <= 1'b0;
        else if (expire) flag <= 1'b1;
        else if (clr)    flag <= 1'b0;
    end

    assign code = code_of(flag);
endmodule

// File: rtl/pace_guard.sv
module pace_guard import pace_pkg::*; #(
    parameter int LIM_W = 16,
    parameter int MON_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  raw_req,
    input  logic                  grant,
    input  logic                  wu_active,
    input  logic                  wu_done,
    input  logic                  wrap_pulse,
    input  logic                  cfg_wr,
    input  logic                  cfg_sel,
    input  logic [MON_W-1:0]      cfg_wdata,
    input  logic                  err_clr,
    output logic                  req_out,
    output logic [MON_W-1:0]      mon_cur,
    output logic                  err_flag,
    output logic [ERR_CODE_W-1:0] err_code
);
    logic [LIM_W-1:0] lim_q;
    logic [MON_W-1:0] mon_q, mon_nxt;
    logic             reload, expire;

    assign reload = cfg_wr || wu_done || wrap_pulse;

    pace_regs #(.LIM_W(LIM_W), .MON_W(MON_W)) u_regs (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .lim_q(lim_q), .mon_q(mon_q), .mon_nxt(mon_nxt)
    );

    pace_spacer #(.LIM_W(LIM_W)) u_spacer (
        .clk(clk), .rst(rst), .raw_req(raw_req), .grant(grant),
        .limit(lim_q), .req_out(req_out)
    );

    pace_deadline #(.MON_W(MON_W)) u_deadline (
        .clk(clk), .rst(rst), .reload(reload), .reload_val(mon_nxt),
        .active(wu_active), .enable(mon_q != '0), .cur(mon_cur), .expire(expire)
    );

    pace_errlat u_err (
        .clk(clk), .rst(rst), .expire(expire), .clr(err_clr),
        .flag(err_flag), .code(err_code)
    );
endmodule

// File: rtl/pace_guard_chk.sv
module pace_guard_chk import pace_pkg::*; #(
    parameter int LIM_W = 16,
    parameter int MON_W = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  raw_req,
    input logic                  grant,
    input logic                  wu_active,
    input logic                  wu_done,
    input logic                  wrap_pulse,
    input logic                  cfg_wr,
    input logic                  err_clr,
    input logic                  req_out,
    input logic [MON_W-1:0]      mon_cur,
    input logic [MON_W-1:0]      mon_q,
    input logic [LIM_W-1:0]      lim_q,
    input logic                  err_flag,
    input logic [ERR_CODE_W-1:0] err_code
);
    logic reload_c, due_c;
    assign reload_c = cfg_wr || wu_done || wrap_pulse;
    assign due_c    = wu_active && !reload_c && (mon_q != '0) && (mon_cur == MON_W'(1));

    a_r2_zero_limit_transparent: assert property (@(posedge clk) disable iff (rst)
        (lim_q == '0) |-> (req_out == raw_req));

    a_r3_gap_after_grant: assert property (@(posedge clk) disable iff (rst)
        (req_out && grant && lim_q > LIM_W'(1) && !cfg_wr) |=> !req_out);

    a_r4_stop_all: assert property (@(posedge clk) disable iff (rst)
        (lim_q == '1) |-> !req_out);

    a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
        req_out |-> raw_req);

    a_r13_pending_held: assert property (@(posedge clk) disable iff (rst)
        (req_out && !grant && !cfg_wr) |=> (!raw_req || req_out));

    a_r6_reload_value: assert property (@(posedge clk) disable iff (rst)
        reload_c |=> (mon_cur == mon_q));

    a_r7_count_down: assert property (@(posedge clk) disable iff (rst)
        (wu_active && !reload_c && mon_q != '0 && mon_cur != '0)
        |=> (mon_cur == $past(mon_cur) - MON_W'(1)));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!wu_active && !reload_c) |=> $stable(mon_cur));

    a_r9_expire_flag: assert property (@(posedge clk) disable iff (rst)
        due_c |=> (err_flag && err_code == ERR_DEADLINE && mon_cur == '0));

    a_r9_rest_at_zero: assert property (@(posedge clk) disable iff (rst)
        (mon_cur == '0 && !reload_c) |=> (mon_cur == '0));

    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        (mon_q == '0 && !err_flag) |=> !err_flag);

    a_r12_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !err_clr) |=> err_flag);

    a_r12_clear: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !due_c) |=> (!err_flag && err_code == ERR_NONE));

    a_r12_code_match: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> (err_code == ERR_DEADLINE));
endmodule

bind pace_guard pace_guard_chk #(.LIM_W(LIM_W), .MON_W(MON_W)) u_chk (
    .clk(clk), .rst(rst), .raw_req(raw_req), .grant(grant),
    .wu_active(wu_active), .wu_done(wu_done), .wrap_pulse(wrap_pulse),
    .cfg_wr(cfg_wr), .err_clr(err_clr), .req_out(req_out),
    .mon_cur(mon_cur), .mon_q(mon_q), .lim_q(lim_q),
    .err_flag(err_flag), .err_code(err_code)
);

// File: tb/pace_guard_test.sv
module pace_guard_test;
    logic        clk = 1'b0;
    logic        rst, raw_req, grant, wu_active, wu_done, wrap_pulse;
    logic        cfg_wr, cfg_sel, err_clr;
    logic [31:0] cfg_wdata;
    logic        req_out, err_flag;
    logic [31:0] mon_cur;
    logic [3:0]  err_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    pace_guard uut (
        .clk(clk), .rst(rst), .raw_req(raw_req), .grant(grant),
        .wu_active(wu_active), .wu_done(wu_done), .wrap_pulse(wrap_pulse),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .err_clr(err_clr), .req_out(req_out), .mon_cur(mon_cur),
        .err_flag(err_flag), .err_code(err_code)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        cyc();
        cfg_wr = 1'b0;
    endtask

    task automatic drain();
        raw_req = 1'b0; grant = 1'b0;
        repeat (8) cyc();
    endtask

    task automatic t_reset();
        #1;
        check("R1 req_out", req_out, 0);
        check("R1 mon_cur", mon_cur, 0);
        check("R1 err_flag", err_flag, 0);
        check("R1 err_code", err_code, 0);
    endtask

    task automatic t_zero_limit();
        raw_req = 1'b1; grant = 1'b1;
        for (int k = 0; k < 6; k++) begin
            #1; check("R2 pass every cycle", req_out, 1);
            cyc();
        end
        raw_req = 1'b0;
        #1; check("R5 no raw request", req_out, 0);
        grant = 1'b0;
    endtask

    task automatic t_spacing();
        int highs = 0;
        drain();
        wr(1'b0, 32'd4);
        raw_req = 1'b1; grant = 1'b1;
        for (int k = 0; k < 16; k++) begin
            #1;
            check("R3 spacing of 4", req_out, (k % 4 == 0) ? 1 : 0);
            if (req_out) highs++;
            cyc();
        end
        check("R3 grants in 16 cycles", highs, 4);
        drain();
    endtask

    task automatic t_hold();
        wr(1'b0, 32'd3);
        raw_req = 1'b1; grant = 1'b0;
        for (int k = 0; k < 5; k++) begin
            #1; check("R13 held without grant", req_out, 1);
            cyc();
        end
        grant = 1'b1;
        #1; check("R13 before grant", req_out, 1);
        cyc();
        grant = 1'b0;
        #1; check("R13 restart gap 1", req_out, 0); cyc();
        #1; check("R13 restart gap 2", req_out, 0); cyc();
        #1; check("R13 reopened", req_out, 1);
        drain();
    endtask

    task automatic t_stop_all();
        wr(1'b0, 32'h0000_FFFF);
        raw_req = 1'b1; grant = 1'b1;
        for (int k = 0; k < 10; k++) begin
            #1; check("R4 all blocked", req_out, 0);
            cyc();
        end
        wr(1'b0, 32'd0);
        #1; check("R4 release to zero limit", req_out, 1);
        drain();
    endtask

    task automatic t_monitor();
        wr(1'b1, 32'd10);
        #1; check("R6 load on monitor write", mon_cur, 10);
        repeat (3) cyc();
        check("R8 idle hold", mon_cur, 10);
        wu_active = 1'b1; repeat (3) cyc(); wu_active = 1'b0;
        #1; check("R7 three decrements", mon_cur, 7);
        wu_done = 1'b1; cyc(); wu_done = 1'b0;
        check("R6 reload on done", mon_cur, 10);
        wu_active = 1'b1; repeat (2) cyc(); wu_active = 1'b0;
        wrap_pulse = 1'b1; cyc(); wrap_pulse = 1'b0;
        check("R6 reload on wrap", mon_cur, 10);
        wu_active = 1'b1; repeat (2) cyc(); wu_active = 1'b0;
        wr(1'b0, 32'd0);
        check("R6 reload on limit write", mon_cur, 10);
        check("R7 no error", err_flag, 0);
    endtask

    task automatic t_expire();
        wr(1'b1, 32'd5);
        wu_active = 1'b1;
        repeat (4) cyc();
        check("R9 one left", mon_cur, 1);
        check("R9 not yet expired", err_flag, 0);
        cyc();
        check("R9 counter zero", mon_cur, 0);
        check("R9 flag set", err_flag, 1);
        check("R9 code 0x6", err_code, 4'h6);
        repeat (3) cyc();
        check("R9 rests at zero", mon_cur, 0);
        raw_req = 1'b1; grant = 1'b1;
        #1; check("R11 requests continue", req_out, 1);
        cyc();
        #1; check("R11 requests continue next", req_out, 1);
        raw_req = 1'b0; grant = 1'b0;
        wu_done = 1'b1; cyc(); wu_done = 1'b0; wu_active = 1'b0;
        check("R9 reload after done", mon_cur, 5);
        check("R12 still set", err_flag, 1);
    endtask

    task automatic t_clear();
        err_clr = 1'b1; cyc(); err_clr = 1'b0;
        check("R12 cleared flag", err_flag, 0);
        check("R12 cleared code", err_code, 0);
        wr(1'b1, 32'd2);
        wu_active = 1'b1; cyc();
        err_clr = 1'b1; cyc(); err_clr = 1'b0; wu_active = 1'b0;
        check("R12 expiry beats clear", err_flag, 1);
        err_clr = 1'b1; cyc(); err_clr = 1'b0;
        check("R12 later clear", err_flag, 0);
    endtask

    task automatic t_on_time();
        wr(1'b1, 32'd5);
        wu_active = 1'b1; repeat (4) cyc();
        wu_done = 1'b1; cyc(); wu_done = 1'b0; wu_active = 1'b0;
        check("R9 done in last cycle no error", err_flag, 0);
        check("R9 reload after on-time done", mon_cur, 5);
    endtask

    task automatic t_disabled();
        wr(1'b1, 32'd0);
        wu_active = 1'b1; repeat (40) cyc(); wu_active = 1'b0;
        check("R10 counter stays zero", mon_cur, 0);
        check("R10 no error", err_flag, 0);
    endtask

    initial begin
        rst = 1'b1; raw_req = 0; grant = 0; wu_active = 0; wu_done = 0;
        wrap_pulse = 0; cfg_wr = 0; cfg_sel = 0; cfg_wdata = '0; err_clr = 0;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        t_reset();
        t_zero_limit();
        t_spacing();
        t_hold();
        t_stop_all();
        t_monitor();
        t_expire();
        t_clear();
        t_on_time();
        t_disabled();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R1-scope run actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule